// File: doc/BRIEF.md
# Configurable Multi-Polynomial CRC Engine

This block computes a cyclic redundancy check over words written to it by software through a small register bus. Software first writes a starting value into the seed register. It then writes the control register to choose the polynomial, the input word size and the data and checksum transforms, and to set the enable bit. Setting the reload bit in that same control write copies the seed into the running CRC. Each data word written afterwards is folded into the running CRC in one clock cycle. The checksum register returns the running CRC, shaped by the output options and masked to the width of the active polynomial.

Four polynomials are available, each processed most significant bit first:

| Polynomial | Width | Generator |
|---|---|---|
| CCITT | 16 | 0x1021 |
| CRC-8 | 8 | 0x07 |
| CRC-16 | 16 | 0x8005 |
| CRC-32 | 32 | 0x04C11DB7 |

Input bytes can be bit-reversed within each byte, complemented, or both. The checksum can be bit-reversed across the active width, complemented, or both. These output transforms act only on the read path and never change the stored CRC.

The bus has no stall. A write completes in the cycle it is presented. A read is combinational from the address.

Top module: `crc_unit`

Register offsets (`wr_addr` / `rd_addr`):

| Offset | Register | Access |
|---|---|---|
| 0 | Control | read/write |
| 1 | Seed | read/write |
| 2 | Data | write; reads as 0 |
| 3 | Checksum | read-only |

Control register bits:

| Bits | Field | Meaning |
|---|---|---|
| 0 | Enable | 1 = data writes are processed |
| 2:1 | Mode | 0 = CCITT, 1 = CRC-8, 2 = CRC-16, 3 = CRC-32 |
| 3 | Input reverse | Bit-reverse each byte of a data write |
| 4 | Input complement | Invert each byte of a data write |
| 5 | Output reverse | Bit-reverse the checksum across the active width |
| 6 | Output complement | Invert the checksum across the active width |
| 8:7 | Word size | 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| 9 | Reload | Write-only; reads as 0 |

## Requirements
- R1: After reset, reads of the control, seed and checksum registers all return 0.
- R2: A control write with bit 9 set loads the seed register, masked to the width of the newly written mode, into the running CRC at that clock edge. Bit 9 always reads back as 0, and bits 31:10 of the control register read as 0.
- R3: While control bit 0 is 0, a write to the data register leaves the running CRC unchanged.
- R4: The mode field in control bits 2:1 selects the polynomial: 0 = CCITT 0x1021 (16 bit), 1 = CRC-8 0x07, 2 = CRC-16 0x8005, 3 = CRC-32 0x04C11DB7. Each is shifted most significant bit first with no built-in reflection or final XOR.
- R5: Control bits 8:7 select how much of a data write is consumed: 0 = bits 7:0; 1 = bits 15:0; 2 or 3 = all 32 bits. The bytes are folded least significant byte first, and the result is readable in the cycle after the write.
- R6: With control bit 3 set, the bits of each consumed byte are reversed before folding.
- R7: With control bit 4 set, each consumed byte is inverted before folding.
- R8: With control bit 5 set, the checksum read is the running CRC bit-reversed across the active width.
- R9: With control bit 6 set, the checksum read is the running CRC inverted across the active width. Neither output option alters the stored CRC.
- R10: The checksum read is zero above the active width: above bit 7 for CRC-8, and above bit 15 for CCITT and CRC-16.
- R11: The seed register and control bits 8:0 read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write register offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |

## Verification
The hardest cases to reach are the combinations of attributes with word size and mode. An input transform can mask an error in byte order, and an output transform can hide a width error, unless they are exercised together. The bench therefore sweeps every mode, every word size and all sixteen attribute settings. For each combination it reloads a fresh seed and writes several pseudo-random words, then compares the checksum against a bitwise model.

Three further checks use specific sequences. A known-answer string pins each polynomial to its published check value. Toggling the output options between reads shows that the stored CRC is untouched. A disabled write followed by re-enabling shows that the state is held.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int CRC_MAX_W = 32;

  typedef enum logic [1:0] {
    MODE_CCITT = 2'd0,
    MODE_C8    = 2'd1,
    MODE_C16   = 2'd2,
    MODE_C32   = 2'd3
  } crc_mode_e;

  // control register image, bit 0 at the bottom
  typedef struct packed {
    logic [1:0] wlen;
    logic       out_cpl;
    logic       out_rev;
    logic       in_cpl;
    logic       in_rev;
    crc_mode_e  mode;
    logic       en;
  } crc_ctrl_t;

  localparam int CTRL_W     = $bits(crc_ctrl_t);
  localparam int RELOAD_BIT = CTRL_W;

  function automatic logic [5:0] mode_width(crc_mode_e m);
    case (m)
      MODE_C8:  return 6'd8;
      MODE_C32: return 6'd32;
      default:  return 6'd16;
    endcase
  endfunction

  function automatic logic [CRC_MAX_W-1:0] mode_mask(crc_mode_e m);
    case (m)
      MODE_C8:  return 32'h0000_00FF;
      MODE_C32: return 32'hFFFF_FFFF;
      default:  return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [CRC_MAX_W-1:0] mode_poly(crc_mode_e m);
    case (m)
      MODE_CCITT: return 32'h0000_1021;
      MODE_C8:    return 32'h0000_0007;
      MODE_C16:   return 32'h0000_8005;
      default:    return 32'h04C1_1DB7;
    endcase
  endfunction

endpackage

// File: rtl/crc_in_lane.sv
module crc_in_lane (
  input  logic [7:0] byte_in,
  input  logic       rev,
  input  logic       cpl,
  output logic [7:0] byte_out
);
  logic [7:0] flipped;

  always_comb begin
    for (int i = 0; i < 8; i++) flipped[i] = byte_in[7-i];
  end

  assign byte_out = (rev ? flipped : byte_in) ^ {8{cpl}};
endmodule

// File: rtl/crc_byte_fold.sv
module crc_byte_fold
  import crc_pkg::*;
(
  input  logic [CRC_MAX_W-1:0] crc_in,
  input  logic [7:0]           byte_in,
  input  crc_mode_e            mode,
  output logic [CRC_MAX_W-1:0] crc_out
);
  logic [5:0]           sh;
  logic [CRC_MAX_W-1:0] acc;
  logic [CRC_MAX_W-1:0] gen;

  // left-align the active width so one shifter serves every mode
  always_comb begin
    sh  = 6'(CRC_MAX_W) - mode_width(mode);
    acc = crc_in << sh;
    gen = mode_poly(mode) << sh;
    for (int i = 7; i >= 0; i--) begin
      if (acc[CRC_MAX_W-1] ^ byte_in[i]) acc = (acc << 1) ^ gen;
      else                               acc = acc << 1;
    end
    crc_out = acc >> sh;
  end
endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage
  import crc_pkg::*;
(
  input  logic [CRC_MAX_W-1:0] state,
  input  crc_mode_e            mode,
  input  logic                 rev,
  input  logic                 cpl,
  output logic [CRC_MAX_W-1:0] sum
);
  logic [CRC_MAX_W-1:0] mirrored;
  logic [CRC_MAX_W-1:0] picked;
  logic [CRC_MAX_W-1:0] msk;
  logic [5:0]           sh;

  always_comb begin
    msk = mode_mask(mode);
    sh  = 6'(CRC_MAX_W) - mode_width(mode);
    for (int i = 0; i < CRC_MAX_W; i++) mirrored[i] = state[CRC_MAX_W-1-i];
    picked = rev ? (mirrored >> sh) : state;
    sum    = (picked ^ (cpl ? msk : '0)) & msk;
  end
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NBYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(3);

  crc_ctrl_t            ctrl_q;
  logic [DATA_W-1:0]    seed_q;
  logic [CRC_MAX_W-1:0] crc_q;
  logic [CRC_MAX_W-1:0] chain [0:NBYTES];
  logic [CRC_MAX_W-1:0] folded;
  logic [CRC_MAX_W-1:0] sum_out;
  crc_mode_e            new_mode;

  assign chain[0] = crc_q;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    logic [7:0] b_prep;
    crc_in_lane u_lane (
      .byte_in (wr_data[8*k +: 8]),
      .rev     (ctrl_q.in_rev),
      .cpl     (ctrl_q.in_cpl),
      .byte_out(b_prep)
    );
    crc_byte_fold u_fold (
      .crc_in (chain[k]),
      .byte_in(b_prep),
      .mode   (ctrl_q.mode),
      .crc_out(chain[k+1])
    );
  end

  always_comb begin
    case (ctrl_q.wlen)
      2'd0:    folded = chain[1];
      2'd1:    folded = chain[2];
      default: folded = chain[NBYTES];
    endcase
  end

  assign new_mode = crc_mode_e'(wr_data[2:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      seed_q <= '0;
      crc_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          ctrl_q <= crc_ctrl_t'(wr_data[CTRL_W-1:0]);
          if (wr_data[RELOAD_BIT]) crc_q <= seed_q & mode_mask(new_mode);
        end
        A_SEED: seed_q <= wr_data;
        A_DATA: if (ctrl_q.en) crc_q <= folded;
        default: ;
      endcase
    end
  end

  crc_out_stage u_out (
    .state(crc_q),
    .mode (ctrl_q.mode),
    .rev  (ctrl_q.out_rev),
    .cpl  (ctrl_q.out_cpl),
    .sum  (sum_out)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
      A_SEED: rd_data = seed_q;
      A_SUM:  rd_data = sum_out;
      default: ;
    endcase
  end
endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic        reload_bit,
  input logic [1:0]  new_mode,
  input logic [1:0]  rd_addr,
  input logic [31:8] rd_hi,
  input logic [31:0] crc_q,
  input logic [31:0] seed_q,
  input logic [8:0]  ctrl
);
  logic [31:0] seed_msk;
  always_comb begin
    case (new_mode)
      2'd1:    seed_msk = seed_q & 32'h0000_00FF;
      2'd3:    seed_msk = seed_q;
      default: seed_msk = seed_q & 32'h0000_FFFF;
    endcase
  end

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && reload_bit) |=> crc_q == $past(seed_msk));

  p_selfclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> rd_hi[31:9] == '0);

  p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && !ctrl[0]) |=> $stable(crc_q));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(crc_q));

  p_mask8_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3 && ctrl[2:1] == 2'd1) |-> rd_hi == '0);

  p_mask16_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3 && !ctrl[1]) |-> rd_hi[31:16] == '0);
endmodule

bind crc_unit crc_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .reload_bit(wr_data[9]),
  .new_mode  (wr_data[2:1]),
  .rd_addr   (rd_addr),
  .rd_hi     (rd_data[31:8]),
  .crc_q     (crc_q),
  .seed_q    (seed_q),
  .ctrl      (ctrl_q)
);

// File: tb/crc_unit_test.sv
module crc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  crc_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic int m_w(int m);
    return (m == 1) ? 8 : (m == 3) ? 32 : 16;
  endfunction
  function automatic logic [31:0] m_msk(int m);
    return (m_w(m) == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_w(m)) - 1);
  endfunction
  function automatic logic [31:0] m_poly(int m);
    case (m)
      0: return 32'h1021;
      1: return 32'h07;
      2: return 32'h8005;
      default: return 32'h04C1_1DB7;
    endcase
  endfunction
  function automatic logic [31:0] m_byte(logic [31:0] s, int m, logic [7:0] b);
    int w = m_w(m);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = ((s >> (w - 1)) & 1) != 0;
      fb = fb ^ b[i];
      s = (s << 1) & m_msk(m);
      if (fb) s = s ^ m_poly(m);
    end
    return s;
  endfunction
  function automatic logic [31:0] m_word(logic [31:0] s, int m, int wl, bit irev, bit icpl,
                                         logic [31:0] word);
    int nb = (wl == 0) ? 1 : (wl == 1) ? 2 : 4;
    for (int k = 0; k < nb; k++) begin
      logic [7:0] b, r;
      b = word[8*k +: 8];
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      if (irev) b = r;
      if (icpl) b = ~b;
      s = m_byte(s, m, b);
    end
    return s;
  endfunction
  function automatic logic [31:0] m_read(logic [31:0] s, int m, bit orev, bit ocpl);
    int w = m_w(m);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = s[w-1-i];
    if (!orev) r = s;
    if (ocpl) r = ~r;
    return r & m_msk(m);
  endfunction
  function automatic logic [31:0] mk_ctrl(bit en, int m, bit irev, bit icpl, bit orev,
                                          bit ocpl, int wl, bit rl);
    return {22'd0, rl, 2'(wl), ocpl, orev, icpl, irev, 2'(m), en};
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask
  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask
  function automatic logic [31:0] nxt(logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    logic [31:0] v, s;
    string digits = "123456789";
    logic [31:0] kat [4] = '{32'h29B1, 32'hF4, 32'hFEE8, 32'h0376_E6E7};
    logic [31:0] kseed [4] = '{32'hFFFF, 32'h0, 32'h0, 32'hFFFF_FFFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    bus_rd(2'd0, v); check("R1 ctrl", v, 0);
    bus_rd(2'd1, v); check("R1 seed", v, 0);
    bus_rd(2'd3, v); check("R1 sum", v, 0);

    // R11 readback, R2 reload bit reads zero and masked seed
    bus_wr(2'd1, 32'hA5A5_1234);
    bus_rd(2'd1, v); check("R11 seed", v, 32'hA5A5_1234);
    bus_wr(2'd0, mk_ctrl(1, 1, 0, 1, 1, 0, 2, 1) | 32'hFFFF_FC00);
    bus_rd(2'd0, v); check("R2 R11 ctrl readback", v, mk_ctrl(1, 1, 0, 1, 1, 0, 2, 0));
    bus_wr(2'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 1));
    bus_rd(2'd3, v); check("R2 reload crc8", v, 32'h34);
    bus_wr(2'd0, mk_ctrl(1, 3, 0, 0, 0, 0, 0, 1));
    bus_rd(2'd3, v); check("R2 reload crc32", v, 32'hA5A5_1234);
    bus_rd(2'd2, v); check("R11 data reads zero", v, 0);

    // R4 known answers, 8-bit writes
    for (int m = 0; m < 4; m++) begin
      bus_wr(2'd1, kseed[m]);
      bus_wr(2'd0, mk_ctrl(1, m, 0, 0, 0, 0, 0, 1));
      for (int i = 0; i < 9; i++) bus_wr(2'd2, {24'd0, digits[i]});
      bus_rd(2'd3, v); check("R4 known answer", v, kat[m]);
    end

    // R3 disabled writes are ignored, state kept on re-enable
    bus_wr(2'd1, 32'h0000_BEEF);
    bus_wr(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 1, 1));
    bus_wr(2'd2, 32'h0000_1357);
    s = m_word(32'hBEEF, 0, 1, 0, 0, 32'h1357);
    bus_wr(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 1, 0));
    bus_wr(2'd2, 32'h0000_9999);
    bus_rd(2'd3, v); check("R3 disabled write", v, s);
    bus_wr(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 1, 0));
    bus_rd(2'd3, v); check("R3 re-enable keeps state", v, s);
    bus_wr(2'd2, 32'h0000_2468);
    s = m_word(s, 0, 1, 0, 0, 32'h2468);
    bus_rd(2'd3, v); check("R3 R5 resumes", v, s);

    // R9 output options leave state untouched
    bus_wr(2'd0, mk_ctrl(1, 0, 0, 0, 1, 1, 1, 0));
    bus_rd(2'd3, v); check("R8 R9 shaped read", v, m_read(s, 0, 1, 1));
    bus_wr(2'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 1, 0));
    bus_rd(2'd3, v); check("R9 raw after toggle", v, s);

    // R4..R10 sweep: every mode, word size and attribute set
    for (int m = 0; m < 4; m++) begin
      for (int wl = 0; wl < 4; wl++) begin
        for (int at = 0; at < 16; at++) begin
          lfsr = nxt(lfsr);
          bus_wr(2'd1, lfsr);
          bus_wr(2'd0, mk_ctrl(1, m, at[0], at[1], at[2], at[3], wl, 1));
          s = lfsr & m_msk(m);
          for (int j = 0; j < 3; j++) begin
            lfsr = nxt(lfsr);
            bus_wr(2'd2, lfsr);
            s = m_word(s, m, wl, at[0], at[1], lfsr);
          end
          bus_rd(2'd3, v);
          check("R4 R5 R6 R7 R8 R9 R10 sweep", v, m_read(s, m, at[2], at[3]));
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule